// File: doc/BRIEF.md
# PIO Timing to Clock-Count Converter

This unit turns nanosecond transfer timings for the two devices on a parallel disk channel into the packed byte values that a channel timing controller loads. For each device it takes three figures: address setup, strobe active width and total cycle length. It also takes the bus clock frequency in MHz, a read-prefetch enable and a ready-wait clock count. From these it produces one cycle-timing byte per device and one miscellaneous byte. The two devices share the miscellaneous byte.

Each nanosecond figure is converted to bus clocks, always rounding up. The recovery time is what is left of the total cycle after setup and active time, and it is converted the same way. Each count is then clamped to the range the controller fields can hold. The two setup counts are merged into a single shared value, so the slower device sets the pace for both. A device flagged absent contributes the smallest legal counts.

Software or a sequencer presents all inputs and pulses `start` for one clock. On the following clock the three bytes appear together with a one-cycle `valid` strobe. The bytes hold until the next `start`.

Top module: `pio_timing_conv`

## Requirements
- R1: Every nanosecond figure converts to clocks as floor((ns × MHz + 999) / 1000), so any fractional clock rounds up.
- R2: Recovery nanoseconds equal cycle minus setup minus active. A negative difference is taken as zero before conversion.
- R3: A present device's setup count is clamped into 1..4.
- R4: A present device's active count is clamped into 1..16.
- R5: A present device's recovery count is clamped into 2..17.
- R6: The shared setup count is the larger of the two devices' setup counts.
- R7: An absent device (its `drv_present` bit 0) uses setup 1, active 1 and recovery 2, so its cycle byte is 8'h00.
- R8: Each cycle byte holds active−1 in bits 7:4 and recovery−2 in bits 3:0. `cyc_byte0` belongs to device 0 and `cyc_byte1` to device 1.
- R9: The misc byte holds the prefetch enable in bit 6, shared setup−1 in bits 5:4, and ready−2 in bits 3:1. Bits 7 and 0 are 0. The ready count is first clamped into 2..9.
- R10: Inputs are sampled on a clock edge where `start` is 1. The results and `valid` = 1 appear after that edge. `valid` is 0 after any edge without `start`, and the bytes then keep their values.
- R11: While `rst` is high, `valid` and all three bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to sample inputs and convert |
| bus_mhz | input | MHZ_W (7) | Bus clock frequency in MHz |
| prefetch_en | input | 1 | Read-prefetch enable copied into misc bit 6 |
| rdy_clks | input | 4 | Ready-wait length in clocks, clamped into 2..9 |
| drv_present | input | 2 | Bit n set when device n is attached |
| dev0_setup_ns | input | NS_W (10) | Device 0 address setup time, ns |
| dev0_active_ns | input | NS_W (10) | Device 0 strobe active time, ns |
| dev0_cycle_ns | input | NS_W (10) | Device 0 total cycle time, ns |
| dev1_setup_ns | input | NS_W (10) | Device 1 address setup time, ns |
| dev1_active_ns | input | NS_W (10) | Device 1 strobe active time, ns |
| dev1_cycle_ns | input | NS_W (10) | Device 1 total cycle time, ns |
| valid | output | 1 | One-cycle strobe marking fresh results |
| cyc_byte0 | output | 8 | Packed cycle timing for device 0 |
| cyc_byte1 | output | 8 | Packed cycle timing for device 1 |
| misc_byte | output | 8 | Packed shared setup, ready and prefetch byte |

## Verification
The assertions assume that `start` is a level sampled at each edge and that all other inputs are steady around the edge where `start` is high. The bench changes inputs only on the falling clock edge, so this assumption holds.

The assertions make no assumption about the size of the timing figures. The stimulus deliberately covers the full input widths: cycles shorter than setup plus active, figures large enough to hit every upper clamp, ready counts below 2 and above 9, and every combination of present and absent devices.

// File: rtl/pio_clk_pkg.sv
package pio_clk_pkg;

    localparam int CNT_W     = 5;
    localparam int RDY_W     = 4;
    localparam int NS_PER_US = 1000;
    localparam int ROUND_UP  = NS_PER_US - 1;

    localparam int SETUP_MIN = 1;
    localparam int SETUP_MAX = 4;
    localparam int ACT_MIN   = 1;
    localparam int ACT_MAX   = 16;
    localparam int REC_MIN   = 2;
    localparam int REC_MAX   = 17;
    localparam int RDY_MIN   = 2;
    localparam int RDY_MAX   = 9;

    localparam int N_DEV     = 2;

    typedef enum logic [1:0] {
        FIG_SETUP  = 2'd0,
        FIG_ACTIVE = 2'd1,
        FIG_RECOV  = 2'd2
    } fig_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] recov;
    } clk_set_t;

    typedef struct packed {
        logic [7:0] cyc0;
        logic [7:0] cyc1;
        logic [7:0] misc;
    } timing_bytes_t;

    function automatic logic [CNT_W-1:0] clamp_cnt(input logic [31:0] v,
                                                  input logic [31:0] lo,
                                                  input logic [31:0] hi);
        logic [31:0] r;
        if (v < lo)      r = lo;
        else if (v > hi) r = hi;
        else             r = v;
        return r[CNT_W-1:0];
    endfunction

    function automatic logic [CNT_W-1:0] max_cnt(input logic [CNT_W-1:0] a,
                                                input logic [CNT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pio_ns2clk.sv
module pio_ns2clk
    import pio_clk_pkg::*;
#(
    parameter int NS_W  = 10,
    parameter int MHZ_W = 7
) (
    input  logic [NS_W-1:0]  ns,
    input  logic [MHZ_W-1:0] mhz,
    output logic [31:0]      clks
);
    localparam int PROD_W = NS_W + MHZ_W;
    localparam int BASE_W = (PROD_W > 10) ? PROD_W : 10;
    localparam int SUM_W  = BASE_W + 1;

    logic [SUM_W-1:0] prod;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] quo;

    always_comb begin
        prod = SUM_W'(ns) * SUM_W'(mhz);
        sum  = prod + SUM_W'(ROUND_UP);
        quo  = sum / SUM_W'(NS_PER_US);
        clks = 32'(quo);
    end
endmodule

// File: rtl/pio_drive_calc.sv
module pio_drive_calc
    import pio_clk_pkg::*;
#(
    parameter int NS_W  = 10,
    parameter int MHZ_W = 7
) (
    input  logic             present,
    input  logic [NS_W-1:0]  setup_ns,
    input  logic [NS_W-1:0]  active_ns,
    input  logic [NS_W-1:0]  cycle_ns,
    input  logic [MHZ_W-1:0] mhz,
    output clk_set_t         counts
);
    localparam int DIFF_W = NS_W + 2;
    localparam int N_FIG  = 3;

    logic signed [DIFF_W-1:0] diff;
    logic [NS_W-1:0]          recov_ns;
    logic [NS_W-1:0]          fig_ns [N_FIG];
    logic [31:0]              fig_clk [N_FIG];

    always_comb begin
        diff = $signed({2'b00, cycle_ns})
             - $signed({2'b00, setup_ns})
             - $signed({2'b00, active_ns});
        recov_ns = diff[DIFF_W-1] ? '0 : diff[NS_W-1:0];
        fig_ns[FIG_SETUP]  = setup_ns;
        fig_ns[FIG_ACTIVE] = active_ns;
        fig_ns[FIG_RECOV]  = recov_ns;
    end

    for (genvar g = 0; g < N_FIG; g++) begin : g_conv
        pio_ns2clk #(.NS_W(NS_W), .MHZ_W(MHZ_W)) u_conv (
            .ns   (fig_ns[g]),
            .mhz  (mhz),
            .clks (fig_clk[g])
        );
    end

    always_comb begin
        if (present) begin
            counts.setup  = clamp_cnt(fig_clk[FIG_SETUP],  SETUP_MIN, SETUP_MAX);
            counts.active = clamp_cnt(fig_clk[FIG_ACTIVE], ACT_MIN,   ACT_MAX);
            counts.recov  = clamp_cnt(fig_clk[FIG_RECOV],  REC_MIN,   REC_MAX);
        end else begin
            counts.setup  = CNT_W'(SETUP_MIN);
            counts.active = CNT_W'(ACT_MIN);
            counts.recov  = CNT_W'(REC_MIN);
        end
    end
endmodule

// File: rtl/pio_byte_pack.sv
module pio_byte_pack
    import pio_clk_pkg::*;
(
    input  clk_set_t         dev [N_DEV],
    input  logic             prefetch,
    input  logic [RDY_W-1:0] rdy,
    output timing_bytes_t    bytes_o
);
    logic [7:0]       cyc [N_DEV];
    logic [CNT_W-1:0] ax;
    logic [CNT_W-1:0] rdy_c;
    logic [CNT_W-1:0] ax_m1;
    logic [CNT_W-1:0] rdy_m2;

    for (genvar d = 0; d < N_DEV; d++) begin : g_cyc
        logic [CNT_W-1:0] act_m1;
        logic [CNT_W-1:0] rec_m2;
        always_comb begin
            act_m1 = dev[d].active - CNT_W'(ACT_MIN);
            rec_m2 = dev[d].recov  - CNT_W'(REC_MIN);
            cyc[d] = {act_m1[3:0], rec_m2[3:0]};
        end
    end

    always_comb begin
        ax     = max_cnt(dev[0].setup, dev[1].setup);
        rdy_c  = clamp_cnt(32'(rdy), RDY_MIN, RDY_MAX);
        ax_m1  = ax - CNT_W'(SETUP_MIN);
        rdy_m2 = rdy_c - CNT_W'(RDY_MIN);
        bytes_o.cyc0 = cyc[0];
        bytes_o.cyc1 = cyc[1];
        bytes_o.misc = {1'b0, prefetch, ax_m1[1:0], rdy_m2[2:0], 1'b0};
    end
endmodule

// File: rtl/pio_timing_conv.sv
module pio_timing_conv
    import pio_clk_pkg::*;
#(
    parameter int NS_W  = 10,
    parameter int MHZ_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [MHZ_W-1:0] bus_mhz,
    input  logic             prefetch_en,
    input  logic [3:0]       rdy_clks,
    input  logic [1:0]       drv_present,
    input  logic [NS_W-1:0]  dev0_setup_ns,
    input  logic [NS_W-1:0]  dev0_active_ns,
    input  logic [NS_W-1:0]  dev0_cycle_ns,
    input  logic [NS_W-1:0]  dev1_setup_ns,
    input  logic [NS_W-1:0]  dev1_active_ns,
    input  logic [NS_W-1:0]  dev1_cycle_ns,
    output logic             valid,
    output logic [7:0]       cyc_byte0,
    output logic [7:0]       cyc_byte1,
    output logic [7:0]       misc_byte
);
    logic [NS_W-1:0] s_ns [N_DEV];
    logic [NS_W-1:0] a_ns [N_DEV];
    logic [NS_W-1:0] c_ns [N_DEV];
    clk_set_t        cnt  [N_DEV];
    timing_bytes_t   nxt;
    timing_bytes_t   cur;
    logic            valid_q;

    always_comb begin
        s_ns[0] = dev0_setup_ns;  s_ns[1] = dev1_setup_ns;
        a_ns[0] = dev0_active_ns; a_ns[1] = dev1_active_ns;
        c_ns[0] = dev0_cycle_ns;  c_ns[1] = dev1_cycle_ns;
    end

    for (genvar d = 0; d < N_DEV; d++) begin : g_dev
        pio_drive_calc #(.NS_W(NS_W), .MHZ_W(MHZ_W)) u_calc (
            .present   (drv_present[d]),
            .setup_ns  (s_ns[d]),
            .active_ns (a_ns[d]),
            .cycle_ns  (c_ns[d]),
            .mhz       (bus_mhz),
            .counts    (cnt[d])
        );
    end

    pio_byte_pack u_pack (
        .dev      (cnt),
        .prefetch (prefetch_en),
        .rdy      (rdy_clks),
        .bytes_o  (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            cur     <= '0;
        end else begin
            valid_q <= start;
            if (start) cur <= nxt;
        end
    end

    assign valid     = valid_q;
    assign cyc_byte0 = cur.cyc0;
    assign cyc_byte1 = cur.cyc1;
    assign misc_byte = cur.misc;
endmodule

module pio_timing_conv_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       prefetch_en,
    input logic [1:0] drv_present,
    input logic       valid,
    input logic [7:0] cyc_byte0,
    input logic [7:0] cyc_byte1,
    input logic [7:0] misc_byte
);
    a_r10_valid_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> valid);
    a_r10_quiet_without_start: assert property (@(posedge clk) disable iff (rst)
        !start |=> !valid);
    a_r10_hold_bytes: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(cyc_byte0) && $stable(cyc_byte1) && $stable(misc_byte)));
    a_r7_absent_dev0: assert property (@(posedge clk) disable iff (rst)
        (start && !drv_present[0]) |=> (cyc_byte0 == 8'h00));
    a_r7_absent_dev1: assert property (@(posedge clk) disable iff (rst)
        (start && !drv_present[1]) |=> (cyc_byte1 == 8'h00));
    a_r6_both_absent_setup: assert property (@(posedge clk) disable iff (rst)
        (start && drv_present == 2'b00) |=> (misc_byte[5:4] == 2'b00));
    a_r9_prefetch_bit: assert property (@(posedge clk) disable iff (rst)
        start |=> (misc_byte[6] == $past(prefetch_en)));
    a_r9_spare_bits: assert property (@(posedge clk) disable iff (rst)
        valid |-> (misc_byte[7] == 1'b0 && misc_byte[0] == 1'b0));
endmodule

bind pio_timing_conv pio_timing_conv_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .prefetch_en (prefetch_en),
    .drv_present (drv_present),
    .valid       (valid),
    .cyc_byte0   (cyc_byte0),
    .cyc_byte1   (cyc_byte1),
    .misc_byte   (misc_byte)
);

// File: tb/pio_timing_conv_tb.sv
module pio_timing_conv_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS_W  = 10;
    localparam int MHZ_W = 7;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [MHZ_W-1:0] bus_mhz = '0;
    logic prefetch_en = 1'b0;
    logic [3:0] rdy_clks = '0;
    logic [1:0] drv_present = '0;
    logic [NS_W-1:0] s0 = '0, a0 = '0, c0 = '0, s1 = '0, a1 = '0, c1 = '0;
    logic valid;
    logic [7:0] cyc_byte0, cyc_byte1, misc_byte;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string cur_req = "R11";

    int exp_valid = 0, exp_c0 = 0, exp_c1 = 0, exp_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_timing_conv #(.NS_W(NS_W), .MHZ_W(MHZ_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .bus_mhz(bus_mhz),
        .prefetch_en(prefetch_en), .rdy_clks(rdy_clks), .drv_present(drv_present),
        .dev0_setup_ns(s0), .dev0_active_ns(a0), .dev0_cycle_ns(c0),
        .dev1_setup_ns(s1), .dev1_active_ns(a1), .dev1_cycle_ns(c1),
        .valid(valid), .cyc_byte0(cyc_byte0), .cyc_byte1(cyc_byte1), .misc_byte(misc_byte)
    );

    function automatic int to_clk(int ns, int mhz);      // R1
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic int lim(int v, int lo, int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic int dev_setup(bit p, int s, int mhz); // R3, R7
        return p ? lim(to_clk(s, mhz), 1, 4) : 1;
    endfunction

    function automatic int dev_cycle(bit p, int s, int a, int c, int mhz); // R2 R4 R5 R8
        int rest, act, rec;
        if (!p) return 0;
        rest = c - s - a;
        if (rest < 0) rest = 0;
        act = lim(to_clk(a, mhz), 1, 16);
        rec = lim(to_clk(rest, mhz), 2, 17);
        return (act - 1) * 16 + (rec - 2);
    endfunction

    // Reference model, advanced at each rising edge.
    always @(posedge clk) begin
        int st0, st1, ax;
        if (rst) begin
            exp_valid <= 0; exp_c0 <= 0; exp_c1 <= 0; exp_m <= 0;
        end else begin
            exp_valid <= int'(start);
            if (start) begin
                exp_c0 <= dev_cycle(drv_present[0], s0, a0, c0, bus_mhz);
                exp_c1 <= dev_cycle(drv_present[1], s1, a1, c1, bus_mhz);
                st0 = dev_setup(drv_present[0], s0, bus_mhz);
                st1 = dev_setup(drv_present[1], s1, bus_mhz);
                ax = (st0 > st1) ? st0 : st1;           // R6
                exp_m <= int'(prefetch_en) * 64 + (ax - 1) * 16
                       + (lim(int'(rdy_clks), 2, 9) - 2) * 2;   // R9
            end
        end
    end

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // Compare on every falling edge.
    always @(negedge clk) begin
        cycles++;
        check("valid", int'(valid), exp_valid);
        check("cyc_byte0", int'(cyc_byte0), exp_c0);
        check("cyc_byte1", int'(cyc_byte1), exp_c1);
        check("misc_byte", int'(misc_byte), exp_m);
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    task automatic run(string req, logic [1:0] p, int mhz, bit pf, int rdy,
                       int xs0, int xa0, int xc0, int xs1, int xa1, int xc1);
        @(negedge clk);
        cur_req = req;
        drv_present = p; bus_mhz = MHZ_W'(mhz); prefetch_en = pf;
        rdy_clks = 4'(rdy);
        s0 = NS_W'(xs0); a0 = NS_W'(xa0); c0 = NS_W'(xc0);
        s1 = NS_W'(xs1); a1 = NS_W'(xa1); c1 = NS_W'(xc1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R10: disturb inputs while idle; outputs must hold
        s0 = ~s0; a1 = ~a1; prefetch_en = ~prefetch_en;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);     // R11 reset state compared
        rst = 1'b0;
        run("R1",  2'b11, 33,  1, 2,  70, 165, 600,  30, 80, 180);
        run("R1",  2'b11, 20,  0, 2,  50, 125, 383,  25, 70, 120);
        run("R2",  2'b11, 40,  1, 3, 100, 200, 150, 300, 500, 0);
        run("R3",  2'b11, 127, 0, 2, 1023, 10, 1023, 0, 0, 0);
        run("R4",  2'b01, 127, 1, 2, 5, 1023, 1023, 0, 0, 0);
        run("R5",  2'b10, 100, 0, 5, 0, 0, 0, 10, 10, 1023);
        run("R6",  2'b11, 66,  1, 2, 10, 100, 300, 55, 100, 300);
        run("R6",  2'b11, 66,  1, 2, 55, 100, 300, 10, 100, 300);
        run("R7",  2'b00, 127, 1, 9, 900, 900, 1023, 900, 900, 1023);
        run("R7",  2'b01, 50,  0, 4, 60, 80, 400, 999, 999, 999);
        run("R9",  2'b11, 33,  1, 0, 70, 165, 600, 70, 165, 600);
        run("R9",  2'b11, 33,  0, 15, 70, 165, 600, 70, 165, 600);
        run("R9",  2'b11, 33,  1, 9, 70, 165, 600, 70, 165, 600);
        run("R8",  2'b11, 0,   0, 2, 500, 500, 1000, 500, 500, 1000);
        // R10: back-to-back starts
        @(negedge clk);
        cur_req = "R10";
        drv_present = 2'b11; bus_mhz = 7'd40; s0 = 10'd30; a0 = 10'd70; c0 = 10'd200;
        s1 = 10'd90; a1 = 10'd290; c1 = 10'd600; start = 1'b1;
        @(negedge clk);
        bus_mhz = 7'd90;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 300; i++) begin
            run("R1", 2'($urandom_range(0, 3)), $urandom_range(0, 127),
                1'($urandom_range(0, 1)), $urandom_range(0, 15),
                $urandom_range(0, 1023), $urandom_range(0, 1023), $urandom_range(0, 1023),
                $urandom_range(0, 1023), $urandom_range(0, 1023), $urandom_range(0, 1023));
        end
        // R11: reset mid-run clears outputs
        @(negedge clk);
        cur_req = "R11";
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule